// File: doc/BRIEF.md
# Bit-Reversed Period Stretch Distributor

This block is a tick generator for a digital PLL or a fractional divider. It produces a repeating frame of 2^IDX_W periods. Each period lasts either N-1 or N clock cycles. The stretch count K says how many periods in a frame take the longer length, and the block spreads those longer periods as evenly as it can across the frame.

The choice is made per period. The block reverses the bit order of the period index and compares the result against K. This interleaves the long periods instead of grouping them at the front of the frame, so the phase error of the resulting tick stream stays within about one clock cycle.

A one-cycle tick marks the last cycle of every period. A frame mark comes with the tick that closes the final period of the frame. N and K are taken at the first cycle of each frame and then held for the whole frame. Loop filtering and phase detection belong to the surrounding logic.

Top module: `stretch_distributor`

## Requirements
- R1: A frame holds 2^IDX_W periods, and `tick` is high for exactly one clock, on the last cycle of each period.
- R2: Every period lasts either N or N-1 clock cycles, where N is the base length in force for the frame.
- R3: Period p is long (N cycles) exactly when reverse(p) < K. reverse(p) moves bit i of the IDX_W-bit index to bit IDX_W-1-i. With IDX_W = 4 and K = 4 the long periods are 0, 4, 8 and 12. With K = 5 they are 0, 2, 4, 8 and 12.
- R4: Each frame holds exactly min(K, 2^IDX_W) long periods. K = 0 makes every period short, and any K of 2^IDX_W or more makes every period long.
- R5: `frame_mark` is high only together with the tick that ends period 2^IDX_W-1.
- R6: `base_len` and `stretch_cnt` are sampled in the first cycle of a frame. A change at any other time has no effect until the next frame begins.
- R7: A base length below 2 is treated as 2, so the short period is never shorter than one cycle.
- R8: While reset is held, the counters stay at zero, and with a base length of at least 3 both outputs stay low. After reset is released, the first period is index 0 of a fresh frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_len | input | LEN_W | Long period length N in clock cycles |
| stretch_cnt | input | IDX_W+1 | Number K of long periods per frame |
| tick | output | 1 | High on the last cycle of each period |
| frame_mark | output | 1 | High with the tick that ends the last period of the frame |

## Verification
The bench measures every period of whole frames and checks which indices came out long. With K = 4 and K = 5 it expects the interleaved index sets. A design that skipped the reversal would lengthen periods 0 to 3 in a row. A design that compared with less-or-equal would add one extra long period.

The extremes K = 0, K = 16 and an out-of-range K = 31 catch a comparison that wraps or loses the top bit of K. N = 2, N = 1 and N = 0 catch a short period that collapses to zero length or underflows.

A base length and stretch count changed in the middle of a frame must leave the remaining periods of that frame untouched and take effect only at the next frame. A design that latched them every period would show the change too early.

// File: rtl/stretch_pkg.sv
package stretch_pkg;
   // Smallest base length the block accepts; lower requests are raised to it.
   localparam int unsigned MIN_BASE_LEN = 2;
endpackage

// File: rtl/stretch_bitrev.sv
module stretch_bitrev #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] idx,
   output logic [W-1:0] rev
);
   for (genvar i = 0; i < W; i++) begin : g_swap
      assign rev[i] = idx[W-1-i];
   end
endmodule

// File: rtl/stretch_len_sel.sv
module stretch_len_sel
   import stretch_pkg::*;
#(
   parameter int unsigned IDX_W = 4,
   parameter int unsigned LEN_W = 8
) (
   input  logic [IDX_W-1:0] rev_idx,
   input  logic [IDX_W:0]   k_val,
   input  logic [LEN_W-1:0] n_val,
   output logic [LEN_W-1:0] last_cnt
);
   localparam logic [LEN_W-1:0] FLOOR = LEN_W'(MIN_BASE_LEN);

   logic             stretch;
   logic [LEN_W-1:0] n_clamped;

   always_comb begin
      stretch   = ({1'b0, rev_idx} < k_val);
      n_clamped = (n_val < FLOOR) ? FLOOR : n_val;
      last_cnt  = stretch ? (n_clamped - LEN_W'(1)) : (n_clamped - LEN_W'(2));
   end
endmodule

// File: rtl/stretch_period_ctr.sv
module stretch_period_ctr #(
   parameter int unsigned LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] term_new,
   output logic             first,
   output logic             done
);
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] term_q;
   logic [LEN_W-1:0] term_use;

   always_comb begin
      first    = (cnt_q == '0);
      term_use = first ? term_new : term_q;
      done     = (cnt_q == term_use);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         term_q <= '0;
      end else begin
         if (first) term_q <= term_new;
         if (done) cnt_q <= '0;
         else      cnt_q <= cnt_q + LEN_W'(1);
      end
   end
endmodule

// File: rtl/stretch_distributor.sv
module stretch_distributor #(
   parameter int unsigned IDX_W = 4,
   parameter int unsigned LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] base_len,
   input  logic [IDX_W:0]   stretch_cnt,
   output logic             tick,
   output logic             frame_mark
);
   if (IDX_W < 1) begin : g_bad_idx
      $error("stretch_distributor: IDX_W must be at least 1");
   end
   if (LEN_W < 2) begin : g_bad_len
      $error("stretch_distributor: LEN_W must be at least 2");
   end

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] idx_rev;
   logic [LEN_W-1:0] n_q;
   logic [IDX_W:0]   k_q;
   logic [LEN_W-1:0] n_use;
   logic [IDX_W:0]   k_use;
   logic [LEN_W-1:0] term_new;
   logic             per_first;
   logic             per_done;
   logic             frame_first;

   assign frame_first = per_first && (idx_q == '0);
   assign n_use       = frame_first ? base_len    : n_q;
   assign k_use       = frame_first ? stretch_cnt : k_q;

   stretch_bitrev #(.W(IDX_W)) u_rev (
      .idx (idx_q),
      .rev (idx_rev)
   );

   stretch_len_sel #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_sel (
      .rev_idx  (idx_rev),
      .k_val    (k_use),
      .n_val    (n_use),
      .last_cnt (term_new)
   );

   stretch_period_ctr #(.LEN_W(LEN_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .term_new (term_new),
      .first    (per_first),
      .done     (per_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         n_q   <= '0;
         k_q   <= '0;
      end else begin
         if (frame_first) begin
            n_q <= base_len;
            k_q <= stretch_cnt;
         end
         if (per_done) idx_q <= idx_q + IDX_W'(1);
      end
   end

   assign tick       = per_done;
   assign frame_mark = per_done && (&idx_q);
endmodule

// File: rtl/stretch_distributor_chk.sv
module stretch_distributor_chk #(
   parameter int unsigned IDX_W = 4,
   parameter int unsigned LEN_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             frame_mark,
   input logic [LEN_W-1:0] n_use,
   input logic [IDX_W:0]   k_use,
   input logic [IDX_W-1:0] idx_q
);
   localparam int unsigned FRAME = 1 << IDX_W;

   logic [LEN_W:0] gap_q;
   logic [IDX_W:0] lc_q;
   logic [LEN_W:0] len_now;
   logic [LEN_W:0] nc;
   logic           is_long;
   logic [IDX_W:0] exp_long;

   always_comb begin
      len_now  = gap_q + (LEN_W+1)'(1);
      nc       = (n_use < LEN_W'(2)) ? (LEN_W+1)'(2) : {1'b0, n_use};
      is_long  = (len_now == nc);
      exp_long = (int'(k_use) >= FRAME) ? (IDX_W+1)'(FRAME) : k_use;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q <= '0;
         lc_q  <= '0;
      end else if (tick) begin
         gap_q <= '0;
         if (frame_mark) lc_q <= '0;
         else            lc_q <= lc_q + (IDX_W+1)'(is_long);
      end else begin
         gap_q <= gap_q + (LEN_W+1)'(1);
      end
   end

   AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> (len_now == nc || len_now == nc - (LEN_W+1)'(1))); // R2
   AST_LONG_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      frame_mark |-> (lc_q + (IDX_W+1)'(is_long) == exp_long)); // R4
   AST_MARK_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      frame_mark |-> tick); // R5
   AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(idx_q)); // R1
   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (idx_q == $past(idx_q) + IDX_W'(1))); // R1
endmodule

bind stretch_distributor stretch_distributor_chk #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .frame_mark (frame_mark),
   .n_use      (n_use),
   .k_use      (k_use),
   .idx_q      (idx_q)
);

// File: tb/stretch_distributor_test.sv
module stretch_distributor_test;
   localparam int IDX_W = 4;
   localparam int LEN_W = 8;
   localparam int NP    = 1 << IDX_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [LEN_W-1:0] base_len = 8'd8;
   logic [IDX_W:0]   stretch_cnt = '0;
   logic             tick;
   logic             frame_mark;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   stretch_distributor #(.IDX_W(IDX_W), .LEN_W(LEN_W)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .base_len    (base_len),
      .stretch_cnt (stretch_cnt),
      .tick        (tick),
      .frame_mark  (frame_mark)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         failures = failures + 1;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int rev_idx(input int p);
      int r = 0;
      for (int b = 0; b < IDX_W; b++) if (p[b]) r |= 1 << (IDX_W - 1 - b);
      return r;
   endfunction

   // Measures one whole frame, called just after the frame's first cycle begins.
   // Optionally drives new inputs right after period chg_at ends (mid-frame).
   task automatic measure_frame(input int n, input int k, input string req,
                                input int chg_at, input int new_n, input int new_k,
                                output int long_mask);
      int nc = (n < 2) ? 2 : n;
      int nlong = 0;
      long_mask = 0;
      for (int p = 0; p < NP; p++) begin
         int len = 0;
         bit mark_seen = 0;
         bit exp_long;
         do begin
            @(negedge clk);
            len++;
            if (frame_mark && !tick) mark_seen = 1;
            if (frame_mark && tick) mark_seen = 1;
         end while (!tick && len < 300);
         exp_long = (rev_idx(p) < k);
         if (len == nc) begin
            long_mask |= 1 << p;
            nlong++;
         end
         check(len == (exp_long ? nc : nc - 1), req, len, exp_long ? nc : nc - 1);
         check(mark_seen == (p == NP - 1), "R5", mark_seen, p == NP - 1);
         if (p == chg_at) begin
            base_len    = LEN_W'(new_n);
            stretch_cnt = (IDX_W+1)'(new_k);
         end
      end
      check(nlong == ((k > NP) ? NP : k), "R4", nlong, (k > NP) ? NP : k);
   endtask

   task automatic set_in(input int n, input int k);
      base_len    = LEN_W'(n);
      stretch_cnt = (IDX_W+1)'(k);
   endtask

   task automatic t_reset();
      int m;
      set_in(8, 4);
      repeat (3) @(negedge clk);
      check(tick == 1'b0, "R8", tick, 0);
      check(frame_mark == 1'b0, "R8", frame_mark, 0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      measure_frame(8, 4, "R8", -1, 0, 0, m);
      check(m == 16'h1111, "R8", m, 16'h1111);
   endtask

   task automatic t_spread();
      int m;
      set_in(10, 4);
      measure_frame(10, 4, "R3", -1, 0, 0, m);
      check(m == 16'h1111, "R3", m, 16'h1111);
      set_in(7, 5);
      measure_frame(7, 5, "R3", -1, 0, 0, m);
      check(m == 16'h1115, "R3", m, 16'h1115);
   endtask

   task automatic t_extremes();
      int m;
      set_in(5, 0);
      measure_frame(5, 0, "R4", -1, 0, 0, m);
      check(m == 0, "R4", m, 0);
      set_in(5, 16);
      measure_frame(5, 16, "R4", -1, 0, 0, m);
      check(m == 16'hFFFF, "R4", m, 16'hFFFF);
      set_in(5, 31);
      measure_frame(5, 31, "R4", -1, 0, 0, m);
      check(m == 16'hFFFF, "R4", m, 16'hFFFF);
   endtask

   task automatic t_min_len();
      int m;
      set_in(2, 5);
      measure_frame(2, 5, "R2", -1, 0, 0, m);
      check(m == 16'h1115, "R2", m, 16'h1115);
      set_in(1, 8);
      measure_frame(1, 8, "R7", -1, 0, 0, m);
      check(m == 16'h5555, "R7", m, 16'h5555);
      set_in(0, 12);
      measure_frame(0, 12, "R7", -1, 0, 0, m);
      check(m == 16'h7777, "R7", m, 16'h7777);
   endtask

   task automatic t_midframe();
      int m;
      set_in(6, 3);
      measure_frame(6, 3, "R6", 2, 9, 12, m);
      check(m == 16'h0111, "R6", m, 16'h0111);
      measure_frame(9, 12, "R6", -1, 0, 0, m);
      check(m == 16'h7777, "R6", m, 16'h7777);
   endtask

   initial begin
      t_reset();
      t_spread();
      t_extremes();
      t_min_len();
      t_midframe();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule